// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a clock-synthesis loop. It counts input clocks and emits one single-clock pulse every N clocks. Internally a prescaler divides either by a fixed ratio (1, 2 or 3) or by one of five dual-modulus pairs P/P+1. A swallow counter makes the prescaler run at P+1 for the first A prescaler cycles of each output period and at P for the rest, and it ends the period after B prescaler cycles. The result is N = P*B + A.

The control inputs behave like register fields held by software. They are the mode code, the A value, the B value, a B-bypass bit and two level-held reset bits. The first reset bit holds the A/B counting. The second holds everything and is also passed out to drive an external reference divider. A new configuration takes effect only at the end of a period, or while the counters are held. A dual-modulus setting that cannot be realised is flagged on `cfg_err_o`, and the divider then drops A.

Top module: `pulse_swallow_div`

## Requirements
- R1: Fixed-divide codes: `mode_i` 3'b000 sets P=1, 3'b001 sets P=2 and 3'b111 sets P=3. With `b_bypass_i`=0 the period is N = P*max(B,1) clocks. `a_val_i` has no effect in these modes.
- R2: Dual-modulus codes: 3'b010 is 2/3, 3'b011 is 4/5, 3'b100 is 8/9, 3'b101 is 16/17 and 3'b110 is 32/33. When B >= A and B >= 3, the period is N = P*B + A clocks.
- R3: In a dual-modulus mode with A=0, no pulse is swallowed and N = P*B.
- R4: With `b_bypass_i`=1 in a fixed-divide mode, N = P. In a dual-modulus mode the bit has no effect.
- R5: A dual-modulus setting with B < A or B < 3 is illegal. For such a setting `cfg_err_o` is 1 and N = P*max(B,1). For every legal setting `cfg_err_o` is 0. `cfg_err_o` reflects the loaded configuration.
- R6: `div_o` is high for exactly one clock per period when N > 1, and it stays high when N = 1. After a hold is released, the first pulse is sampled N clocks later.
- R7: While `hold_ab_i`=1, the counters stay at their start and `div_o` is 0. The hold lasts for as long as the bit is 1.
- R8: While `hold_all_i`=1, the same hold applies and `r_rst_o`=1. Otherwise `r_rst_o`=0.
- R9: Mode, A, B and bypass are loaded only at the terminal count or while a hold bit is 1. A period already in progress finishes with the old setting.
- R10: Asynchronous reset `rst_ni`=0 forces `div_o`=0 and `cfg_err_o`=0 and loads the 32/33 mode with A=0 and B=1. With both hold bits 0, the first pulse therefore comes 32 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Prescaler mode code |
| a_val_i | input | A_W | Swallow count A |
| b_val_i | input | B_W | Prescaler cycles per period B |
| b_bypass_i | input | 1 | Force B to 1 in fixed-divide modes |
| hold_ab_i | input | 1 | Level-held reset of the A/B counting |
| hold_all_i | input | 1 | Level-held reset of all counting, mirrored out |
| div_o | output | 1 | One-clock pulse per output period |
| cfg_err_o | output | 1 | Loaded dual-modulus setting is illegal |
| r_rst_o | output | 1 | Reset for an external reference divider |

## Verification
The bench sweeps all eight mode codes against A in {0,1,4}, B in {1,3,6} and both bypass values. It measures the latency after release and two successive periods against P*B + A computed arithmetically.

The sweep is built to separate specific errors:
- A=0 against A>0 separates the swallow path from plain division.
- B below 3 or below A exercises the fallback and the error flag.
- Bypass in each family shows that the bit is honoured only for fixed divide.
- B=0 and a mid-period change of setting check the fallback and the load-at-terminal-count rule.

Long holds on each reset bit confirm that the output stays quiet and that `r_rst_o` follows only the reset-all bit.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  localparam int PW = 6;  // prescaler ratio width, holds up to 33

  typedef struct packed {
    logic          dual;
    logic [PW-1:0] p;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] code);
    mode_dec_t d;
    case (code)
      3'b000:  d = '{dual: 1'b0, p: PW'(1)};
      3'b001:  d = '{dual: 1'b0, p: PW'(2)};
      3'b111:  d = '{dual: 1'b0, p: PW'(3)};
      3'b010:  d = '{dual: 1'b1, p: PW'(2)};
      3'b011:  d = '{dual: 1'b1, p: PW'(4)};
      3'b100:  d = '{dual: 1'b1, p: PW'(8)};
      3'b101:  d = '{dual: 1'b1, p: PW'(16)};
      default: d = '{dual: 1'b1, p: PW'(32)};
    endcase
    return d;
  endfunction
endpackage

// File: rtl/psd_cfg_decode.sv
`timescale 1ns/1ps
module psd_cfg_decode
  import psd_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic [2:0]     mode_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           bypass_i,
  output logic [PW-1:0]  p_o,
  output logic [A_W-1:0] a_o,
  output logic [B_W-1:0] b_o,
  output logic           err_o
);
  localparam int CW = (A_W > B_W) ? A_W : B_W;

  mode_dec_t      dec;
  logic [CW-1:0]  a_x, b_x;
  logic [B_W-1:0] b_nz;
  logic           legal;

  always_comb begin
    dec   = decode_mode(mode_i);
    a_x   = CW'(a_i);
    b_x   = CW'(b_i);
    b_nz  = (b_i == '0) ? B_W'(1) : b_i;
    legal = (b_x >= a_x) && (b_x >= CW'(3));
    p_o   = dec.p;
    if (!dec.dual) begin
      a_o   = '0;
      b_o   = bypass_i ? B_W'(1) : b_nz;
      err_o = 1'b0;
    end else if (legal) begin
      a_o   = a_i;
      b_o   = b_i;
      err_o = 1'b0;
    end else begin
      // fallback: drop the swallow count
      a_o   = '0;
      b_o   = b_nz;
      err_o = 1'b1;
    end
  end
endmodule

// File: rtl/psd_prescaler.sv
`timescale 1ns/1ps
module psd_prescaler
  import psd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [PW-1:0] p_i,
  input  logic          swallow_i,
  output logic          tick_o,
  output logic [PW-1:0] cnt_o
);
  logic [PW-1:0] cnt_q, last;

  // modulus is P, or P+1 while swallowing
  assign last   = p_i + PW'(swallow_i) - PW'(1);
  assign tick_o = (cnt_q == last);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/psd_swallow_ctr.sv
`timescale 1ns/1ps
module psd_swallow_ctr #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           tick_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           swallow_o,
  output logic           term_o,
  output logic [B_W-1:0] cnt_o
);
  localparam int CW = (A_W > B_W) ? A_W : B_W;

  logic [B_W-1:0] cnt_q;

  // one count per prescaler cycle: first A cycles swallow, cycle B ends period
  assign swallow_o = CW'(cnt_q) < CW'(a_i);
  assign term_o    = tick_i && (cnt_q == b_i - B_W'(1));
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (tick_i)   cnt_q <= term_o ? '0 : cnt_q + B_W'(1);
  end
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     mode_i,
  input  logic [A_W-1:0] a_val_i,
  input  logic [B_W-1:0] b_val_i,
  input  logic           b_bypass_i,
  input  logic           hold_ab_i,
  input  logic           hold_all_i,
  output logic           div_o,
  output logic           cfg_err_o,
  output logic           r_rst_o
);
  logic           hold_any, term, tick, swallow, div_q;
  logic [PW-1:0]  nxt_p, act_p, pre_cnt;
  logic [A_W-1:0] nxt_a, act_a;
  logic [B_W-1:0] nxt_b, act_b, pcount;
  logic           nxt_err, act_err;

  assign hold_any = hold_ab_i | hold_all_i;

  psd_cfg_decode #(.A_W(A_W), .B_W(B_W)) i_dec (
    .mode_i   (mode_i),
    .a_i      (a_val_i),
    .b_i      (b_val_i),
    .bypass_i (b_bypass_i),
    .p_o      (nxt_p),
    .a_o      (nxt_a),
    .b_o      (nxt_b),
    .err_o    (nxt_err)
  );

  // shadow of the setting in use; refreshed only at period end or in hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_p   <= PW'(32);
      act_a   <= '0;
      act_b   <= B_W'(1);
      act_err <= 1'b0;
    end else if (hold_any || term) begin
      act_p   <= nxt_p;
      act_a   <= nxt_a;
      act_b   <= nxt_b;
      act_err <= nxt_err;
    end
  end

  psd_prescaler i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (hold_any),
    .p_i       (act_p),
    .swallow_i (swallow),
    .tick_o    (tick),
    .cnt_o     (pre_cnt)
  );

  psd_swallow_ctr #(.A_W(A_W), .B_W(B_W)) i_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (hold_any),
    .tick_i    (tick),
    .a_i       (act_a),
    .b_i       (act_b),
    .swallow_o (swallow),
    .term_o    (term),
    .cnt_o     (pcount)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= term & ~hold_any;
  end

  assign div_o     = div_q & ~hold_any;
  assign cfg_err_o = act_err;
  assign r_rst_o   = hold_all_i;
endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/1ps
module psd_checker
  import psd_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hold_any,
  input logic           term,
  input logic           div_o,
  input logic           cfg_err_o,
  input logic [PW-1:0]  act_p,
  input logic [A_W-1:0] act_a,
  input logic [B_W-1:0] act_b,
  input logic [PW-1:0]  pre_cnt,
  input logic [B_W-1:0] pcount
);
  logic [31:0] n_now;
  assign n_now = 32'(act_p) * 32'(act_b) + 32'(act_a);

  // R6: pulse is one clock wide unless the period is one clock
  assert_pulse_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && n_now > 32'd1 && !term) |=> !div_o);

  // R5: an illegal setting never swallows
  assert_err_fallback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (act_a == '0));

  // R7: held counters stay at their start
  assert_hold_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_any |=> (pre_cnt == '0 && pcount == '0));

  // R9: setting in use changes only at period end or in hold
  assert_cfg_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hold_any || term) |=> ($stable(act_p) && $stable(act_a) && $stable(act_b)));

  // R2: prescaler never exceeds P+1 states
  assert_pre_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt <= act_p);
endmodule

bind pulse_swallow_div psd_checker #(.A_W(A_W), .B_W(B_W)) i_psd_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hold_any  (hold_any),
  .term      (term),
  .div_o     (div_o),
  .cfg_err_o (cfg_err_o),
  .act_p     (act_p),
  .act_a     (act_a),
  .act_b     (act_b),
  .pre_cnt   (pre_cnt),
  .pcount    (pcount)
);

// File: tb/test_pulse_swallow_div.sv
`timescale 1ns/1ps
module test_pulse_swallow_div;
  localparam int A_W = 6;
  localparam int B_W = 13;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [2:0]     mode_i = 3'b000;
  logic [A_W-1:0] a_val_i = '0;
  logic [B_W-1:0] b_val_i = B_W'(5);
  logic           b_bypass_i = 1'b0;
  logic           hold_ab_i = 1'b0;
  logic           hold_all_i = 1'b0;
  logic           div_o, cfg_err_o, r_rst_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pulse_swallow_div #(.A_W(A_W), .B_W(B_W)) i_pulse_swallow_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .a_val_i(a_val_i),
    .b_val_i(b_val_i), .b_bypass_i(b_bypass_i), .hold_ab_i(hold_ab_i),
    .hold_all_i(hold_all_i), .div_o(div_o), .cfg_err_o(cfg_err_o), .r_rst_o(r_rst_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk_i);
      cnt++;
    end while (!div_o && cnt < 4000);
  endtask

  function automatic void model(input int m, input int a, input int b, input int byp,
                                output int n, output int err);
    int p, bb;
    bb  = (b == 0) ? 1 : b;
    err = 0;
    if (m == 0 || m == 1 || m == 7) begin
      p = (m == 0) ? 1 : (m == 1) ? 2 : 3;
      n = (byp != 0) ? p : p * bb;
    end else begin
      p = 1 << (m - 1);
      if (b < a || b < 3) begin
        err = 1;
        n = p * bb;
      end else n = p * b + a;
    end
  endfunction

  task automatic set_cfg(input int m, input int a, input int b, input int byp);
    mode_i     = 3'(m);
    a_val_i    = A_W'(a);
    b_val_i    = B_W'(b);
    b_bypass_i = byp[0];
  endtask

  task automatic run_cfg(input int m, input int a, input int b, input int byp);
    int n, err, c;
    string tag;
    model(m, a, b, byp, n, err);
    if (err != 0)                         tag = "R5";
    else if (byp != 0)                    tag = "R4";
    else if (m == 0 || m == 1 || m == 7)  tag = "R1";
    else if (a == 0)                      tag = "R3";
    else                                  tag = "R2";
    @(negedge clk_i);
    hold_ab_i = 1'b1;
    set_cfg(m, a, b, byp);
    repeat (2) @(negedge clk_i);
    chk($sformatf("R5 err flag m=%0d a=%0d b=%0d", m, a, b), int'(cfg_err_o), err);
    hold_ab_i = 1'b0;
    wait_pulse(c);
    chk($sformatf("R6 latency m=%0d a=%0d b=%0d byp=%0d", m, a, b, byp), c, n);
    if (n > 1) begin
      @(negedge clk_i);
      chk("R6 width", int'(div_o), 0);
      wait_pulse(c);
      c++;
    end else wait_pulse(c);
    chk($sformatf("%s period m=%0d a=%0d b=%0d byp=%0d", tag, m, a, b, byp), c, n);
    wait_pulse(c);
    chk($sformatf("%s period2 m=%0d a=%0d b=%0d byp=%0d", tag, m, a, b, byp), c, n);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int c, highs, rmis;
    // R10: reset state and default 32/33 setting
    repeat (3) @(negedge clk_i);
    chk("R10 div_o in reset", int'(div_o), 0);
    chk("R10 cfg_err_o in reset", int'(cfg_err_o), 0);
    chk("R8 r_rst_o idle", int'(r_rst_o), 0);
    rst_ni = 1'b1;
    wait_pulse(c);
    chk("R10 first period after reset", c, 32);
    wait_pulse(c);
    chk("R10 inputs loaded at terminal", c, 5);

    // sweep
    for (int m = 0; m < 8; m++)
      for (int ai = 0; ai < 3; ai++)
        for (int bi = 0; bi < 3; bi++)
          for (int byp = 0; byp < 2; byp++)
            run_cfg(m, (ai == 0) ? 0 : (ai == 1) ? 1 : 4,
                    (bi == 0) ? 1 : (bi == 1) ? 3 : 6, byp);
    run_cfg(1, 0, 0, 0);
    run_cfg(4, 0, 0, 0);
    run_cfg(3, 3, 3, 0);

    // R9: mid-period change finishes old period first
    run_cfg(1, 0, 4, 0);
    repeat (2) @(negedge clk_i);
    set_cfg(4, 1, 3, 0);
    wait_pulse(c);
    chk("R9 old period kept", c + 2, 8);
    wait_pulse(c);
    chk("R9 new period", c, 25);

    // R7: hold A/B counting
    @(negedge clk_i);
    hold_ab_i = 1'b1;
    set_cfg(1, 0, 1, 0);
    highs = 0; rmis = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (div_o) highs++;
      if (r_rst_o) rmis++;
    end
    chk("R7 div_o quiet in hold", highs, 0);
    chk("R8 r_rst_o low under A/B hold", rmis, 0);
    hold_ab_i = 1'b0;
    wait_pulse(c);
    chk("R7 release latency", c, 2);

    // R8: hold everything
    @(negedge clk_i);
    hold_all_i = 1'b1;
    highs = 0; rmis = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (div_o) highs++;
      if (!r_rst_o) rmis++;
    end
    chk("R8 div_o quiet in hold", highs, 0);
    chk("R8 r_rst_o mirrors", rmis, 0);
    hold_all_i = 1'b0;
    #1;
    chk("R8 r_rst_o released", int'(r_rst_o), 0);
    wait_pulse(c);
    chk("R8 release latency", c, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule